// File: doc/BRIEF.md
# Indexed Load/Store Address Generator

This unit forms the memory address of a load or store from a base register value and an offset. The offset is either a small unsigned immediate or a second register value. A register offset first passes through a barrel shifter that can shift left, shift right logically or arithmetically, rotate right, or rotate right by one through a carry bit. The offset is added to or subtracted from the base. The indexing mode then decides two things: which value goes to memory, and whether the base register is updated.

A request is qualified by a valid bit, and the response appears one clock later. In plain mode the sum is the access address and nothing is written back. In pre-indexed mode the sum is both the access address and the writeback value. In post-indexed mode the unmodified base is the access address and the sum is the writeback value. Two strobes tell the surrounding pipeline the order of events. Pre-indexed mode gives the writeback strobe in the response cycle and the access strobe in the next cycle. Post-indexed mode gives them in the opposite order.

Top module: `addr_index_unit`

## Requirements
- R1: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low in every other cycle.
- R2: With `req_use_reg` = 0 the offset is `req_imm` zero-extended to the data width. The offset sum is `base - offset` when `req_sub` = 1 and `base + offset` otherwise, both modulo 2^W.
- R3: With `req_use_reg` = 1 the offset is `req_index` transformed by `req_shop`: 0 shift left, 1 logical shift right, 2 arithmetic shift right, 3 rotate right, each by `req_shamt`. An amount of 0 leaves the value unchanged.
- R4: `req_shop` = 4 gives `{req_carry_in, req_index[W-1:1]}` and ignores `req_shamt`. Codes 5 to 7 pass `req_index` through unshifted.
- R5: Mode 0 (plain) gives `rsp_addr` = sum and `rsp_wb_en` = 0, with one access strobe in the response cycle and no writeback strobe.
- R6: Mode 1 (pre-indexed) gives `rsp_addr` = sum, `rsp_wb_en` = 1 and `rsp_wb_data` = sum.
- R7: Mode 2 (post-indexed) gives `rsp_addr` = the request's base, `rsp_wb_en` = 1 and `rsp_wb_data` = sum.
- R8: For a pre-indexed request, `seq_wb` is high in the response cycle and `seq_access` is high in the following cycle.
- R9: For a post-indexed request, `seq_access` is high in the response cycle and `seq_wb` is high in the following cycle. When strobes from adjacent requests fall in the same cycle, they merge.
- R10: Mode 3 behaves exactly as mode 0.
- R11: While `rst_n` is low at a clock edge, `rsp_valid`, `seq_access` and `seq_wb` are low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request qualifier |
| req_mode | input | 2 | 0 plain, 1 pre-indexed, 2 post-indexed, 3 as plain |
| req_sub | input | 1 | Subtract the offset instead of adding it |
| req_use_reg | input | 1 | Select the shifted register offset instead of the immediate |
| req_base | input | W | Base register value |
| req_imm | input | IW | Unsigned immediate offset |
| req_index | input | W | Offset register value |
| req_shop | input | 3 | Shift operation code |
| req_shamt | input | SW | Shift amount |
| req_carry_in | input | 1 | Carry bit used by rotate-with-carry |
| rsp_valid | output | 1 | Response qualifier |
| rsp_addr | output | W | Memory access address |
| rsp_wb_en | output | 1 | Base writeback required |
| rsp_wb_data | output | W | New base value |
| seq_access | output | 1 | Memory access strobe |
| seq_wb | output | 1 | Base writeback strobe |

## Verification
A wrong shifter or adder result shows at `rsp_addr` or `rsp_wb_data` in the single response cycle of the request that caused it. So each vector uses a base and an offset that make every shift code, the rotate wrap, the sign fill and the modular wrap visible in the low and high bits. A fault in the sequencing state appears as a missing or extra strobe at most two cycles after the request. Back-to-back pre- and post-indexed requests make their second-phase and first-phase strobes coincide, which exposes a lost pending strobe at once.

// File: rtl/agu_pkg.sv
// Package: codes shared by the address generator and its checker.
// Assumes 2-bit mode and 3-bit shift-operation encodings.
package agu_pkg;
    localparam logic [1:0] MD_PLAIN = 2'd0;
    localparam logic [1:0] MD_PRE   = 2'd1;
    localparam logic [1:0] MD_POST  = 2'd2;
    localparam logic [1:0] MD_ALIAS = 2'd3;

    localparam logic [2:0] SH_LSL = 3'd0;
    localparam logic [2:0] SH_LSR = 3'd1;
    localparam logic [2:0] SH_ASR = 3'd2;
    localparam logic [2:0] SH_ROR = 3'd3;
    localparam logic [2:0] SH_RRX = 3'd4;

    // Order of strobes for one request: now = response cycle, next = cycle after.
    typedef struct packed {
        logic acc_now;
        logic wb_now;
        logic acc_next;
        logic wb_next;
    } seq_plan_t;
endpackage

// File: rtl/agu_shifter.sv
// Module: scales a register offset by shift or rotate.
// Assumes SW = clog2(W); codes above rotate-with-carry pass the value through.
module agu_shifter #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    input  logic [2:0]    op,
    input  logic [SW-1:0] amt,
    input  logic          cin,
    output logic [W-1:0]  res
);
    import agu_pkg::*;

    logic [2*W-1:0] dbl;

    // Select the shift result for the requested operation.
    always_comb begin
        dbl = {val, val} >> amt;
        case (op)
            SH_LSL:  res = val << amt;
            SH_LSR:  res = val >> amt;
            SH_ASR:  res = W'($signed(val) >>> amt);
            SH_ROR:  res = dbl[W-1:0];
            SH_RRX:  res = {cin, val[W-1:1]};
            default: res = val;
        endcase
    end
endmodule

// File: rtl/agu_combine.sv
// Module: adds or subtracts the offset and picks access address and writeback.
// Assumes IW < W; the immediate is unsigned and zero-extended.
module agu_combine #(
    parameter int W  = 32,
    parameter int IW = 12
) (
    input  logic [W-1:0]          base,
    input  logic [IW-1:0]         imm,
    input  logic [W-1:0]          shifted,
    input  logic                  use_reg,
    input  logic                  sub,
    input  logic [1:0]            mode,
    output logic [W-1:0]          addr,
    output logic                  wb_en,
    output logic [W-1:0]          wb_data,
    output agu_pkg::seq_plan_t    plan
);
    import agu_pkg::*;

    localparam int PADW = W - IW;

    logic [W-1:0] offset;
    logic [W-1:0] sum;

    // Pick the offset source and form base plus or minus offset.
    always_comb begin
        offset = use_reg ? shifted : {{PADW{1'b0}}, imm};
        sum    = sub ? (base - offset) : (base + offset);
    end

    // Choose address, writeback and strobe order by indexing mode.
    always_comb begin
        wb_data = sum;
        plan    = '{acc_now: 1'b1, wb_now: 1'b0, acc_next: 1'b0, wb_next: 1'b0};
        case (mode)
            MD_PRE: begin
                addr  = sum;
                wb_en = 1'b1;
                plan  = '{acc_now: 1'b0, wb_now: 1'b1, acc_next: 1'b1, wb_next: 1'b0};
            end
            MD_POST: begin
                addr  = base;
                wb_en = 1'b1;
                plan  = '{acc_now: 1'b1, wb_now: 1'b0, acc_next: 1'b0, wb_next: 1'b1};
            end
            default: begin
                addr  = sum;
                wb_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/agu_sequencer.sv
// Module: turns a strobe plan into access/writeback strobes over two cycles.
// Assumes overlapping strobes from adjacent requests are merged by OR.
module agu_sequencer (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  agu_pkg::seq_plan_t plan,
    output logic               seq_access,
    output logic               seq_wb
);
    import agu_pkg::*;

    seq_plan_t stage1;
    logic      acc_late;
    logic      wb_late;

    // Capture the plan of an accepted request; clear it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    stage1 <= '0;
        else if (fire) stage1 <= plan;
        else           stage1 <= '0;
    end

    // Delay the second-phase strobes by one more cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_late <= 1'b0;
            wb_late  <= 1'b0;
        end else begin
            acc_late <= stage1.acc_next;
            wb_late  <= stage1.wb_next;
        end
    end

    // Merge first-phase and second-phase strobes.
    always_comb begin
        seq_access = stage1.acc_now | acc_late;
        seq_wb     = stage1.wb_now  | wb_late;
    end
endmodule

// File: rtl/addr_index_unit.sv
// Module: top of the indexed address generator; registers the response.
// Assumes requests may arrive every cycle; response follows one clock later.
module addr_index_unit #(
    parameter int W  = 32,
    parameter int IW = 12,
    parameter int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_mode,
    input  logic          req_sub,
    input  logic          req_use_reg,
    input  logic [W-1:0]  req_base,
    input  logic [IW-1:0] req_imm,
    input  logic [W-1:0]  req_index,
    input  logic [2:0]    req_shop,
    input  logic [SW-1:0] req_shamt,
    input  logic          req_carry_in,
    output logic          rsp_valid,
    output logic [W-1:0]  rsp_addr,
    output logic          rsp_wb_en,
    output logic [W-1:0]  rsp_wb_data,
    output logic          seq_access,
    output logic          seq_wb
);
    import agu_pkg::*;

    logic [W-1:0] shifted;
    logic [W-1:0] c_addr;
    logic         c_wb_en;
    logic [W-1:0] c_wb_data;
    seq_plan_t    c_plan;

    agu_shifter #(.W(W), .SW(SW)) u_shift (
        .val (req_index),
        .op  (req_shop),
        .amt (req_shamt),
        .cin (req_carry_in),
        .res (shifted)
    );

    agu_combine #(.W(W), .IW(IW)) u_comb (
        .base    (req_base),
        .imm     (req_imm),
        .shifted (shifted),
        .use_reg (req_use_reg),
        .sub     (req_sub),
        .mode    (req_mode),
        .addr    (c_addr),
        .wb_en   (c_wb_en),
        .wb_data (c_wb_data),
        .plan    (c_plan)
    );

    agu_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (req_valid),
        .plan       (c_plan),
        .seq_access (seq_access),
        .seq_wb     (seq_wb)
    );

    // Response valid tracks the request one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= req_valid;
    end

    // Capture the response fields of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_addr    <= '0;
            rsp_wb_en   <= 1'b0;
            rsp_wb_data <= '0;
        end else if (req_valid) begin
            rsp_addr    <= c_addr;
            rsp_wb_en   <= c_wb_en;
            rsp_wb_data <= c_wb_data;
        end
    end
endmodule

// File: rtl/agu_checker.sv
// Module: temporal properties of the address generator, bound to the top.
// Assumes the default package encodings for mode.
module agu_checker #(
    parameter int W  = 32,
    parameter int IW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [1:0]    req_mode,
    input logic          req_sub,
    input logic          req_use_reg,
    input logic [W-1:0]  req_base,
    input logic [IW-1:0] req_imm,
    input logic          rsp_valid,
    input logic [W-1:0]  rsp_addr,
    input logic          rsp_wb_en,
    input logic [W-1:0]  rsp_wb_data,
    input logic          seq_access,
    input logic          seq_wb
);
    import agu_pkg::*;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R1
    AST_IMM_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_use_reg && !req_sub && req_mode != MD_POST)
        |=> rsp_addr == $past(req_base) + W'($past(req_imm))); // R2
    AST_PLAIN_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_mode == MD_PLAIN || req_mode == MD_ALIAS)) |=> !rsp_wb_en); // R5
    AST_PRE_ADDR_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == MD_PRE) |=> (rsp_wb_en && rsp_addr == rsp_wb_data)); // R6
    AST_POST_ADDR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == MD_POST) |=> (rsp_wb_en && rsp_addr == $past(req_base))); // R7
    AST_PRE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == MD_PRE) |=> seq_wb ##1 seq_access); // R8
    AST_POST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == MD_POST) |=> seq_access ##1 seq_wb); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !seq_access && !seq_wb)); // R11
endmodule

bind addr_index_unit agu_checker #(.W(W), .IW(IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_mode    (req_mode),
    .req_sub     (req_sub),
    .req_use_reg (req_use_reg),
    .req_base    (req_base),
    .req_imm     (req_imm),
    .rsp_valid   (rsp_valid),
    .rsp_addr    (rsp_addr),
    .rsp_wb_en   (rsp_wb_en),
    .rsp_wb_data (rsp_wb_data),
    .seq_access  (seq_access),
    .seq_wb      (seq_wb)
);

// File: tb/test_addr_index_unit.sv
// Bench: scoreboard for the indexed address generator.
module test_addr_index_unit;
    localparam int W  = 32;
    localparam int IW = 12;
    localparam int SW = 5;

    typedef struct {
        int          cyc;
        logic [31:0] addr;
        logic        wb_en;
        logic [31:0] wb_data;
        logic        acc1;
        logic        wb1;
        logic        acc2;
        logic        wb2;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_mode = '0;
    logic          req_sub = 1'b0;
    logic          req_use_reg = 1'b0;
    logic [W-1:0]  req_base = '0;
    logic [IW-1:0] req_imm = '0;
    logic [W-1:0]  req_index = '0;
    logic [2:0]    req_shop = '0;
    logic [SW-1:0] req_shamt = '0;
    logic          req_carry_in = 1'b0;
    logic          rsp_valid;
    logic [W-1:0]  rsp_addr;
    logic          rsp_wb_en;
    logic [W-1:0]  rsp_wb_data;
    logic          seq_access;
    logic          seq_wb;

    int   n_checks = 0;
    int   n_fails  = 0;
    int   cyc      = 0;
    bit   done     = 1'b0;
    exp_t sb[$];

    addr_index_unit #(.W(W), .IW(IW), .SW(SW)) i_addr_index_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_sub(req_sub), .req_use_reg(req_use_reg), .req_base(req_base),
        .req_imm(req_imm), .req_index(req_index), .req_shop(req_shop),
        .req_shamt(req_shamt), .req_carry_in(req_carry_in), .rsp_valid(rsp_valid),
        .rsp_addr(rsp_addr), .rsp_wb_en(rsp_wb_en), .rsp_wb_data(rsp_wb_data),
        .seq_access(seq_access), .seq_wb(seq_wb)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: call just after a rising edge; off is the hand-computed offset.
    task automatic send(input logic [1:0] mode, input logic sub, input logic use_reg,
                        input logic [31:0] base, input logic [11:0] imm,
                        input logic [31:0] idx, input logic [2:0] op,
                        input logic [4:0] amt, input logic cin,
                        input logic [31:0] off, input string tag, input bit keep);
        exp_t e;
        logic [31:0] sum;
        sum = sub ? base - off : base + off;
        e.cyc = cyc; e.tag = tag; e.wb_data = sum;
        e.acc1 = 0; e.wb1 = 0; e.acc2 = 0; e.wb2 = 0;
        if (mode == 2'd1) begin
            e.addr = sum;  e.wb_en = 1; e.wb1 = 1; e.acc2 = 1;
        end else if (mode == 2'd2) begin
            e.addr = base; e.wb_en = 1; e.acc1 = 1; e.wb2 = 1;
        end else begin
            e.addr = sum;  e.wb_en = 0; e.acc1 = 1;
        end
        sb.push_back(e);
        req_valid = 1; req_mode = mode; req_sub = sub; req_use_reg = use_reg;
        req_base = base; req_imm = imm; req_index = idx; req_shop = op;
        req_shamt = amt; req_carry_in = cin;
        @(posedge clk); #1;
        if (!keep) req_valid = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    // Monitor: compares responses and merged strobes at the falling edge.
    initial begin : monitor
        logic pend_acc, pend_wb, exp_acc, exp_wb, exp_v;
        pend_acc = 0; pend_wb = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                check("R11 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
                check("R11 strobes in reset", {30'b0, seq_access, seq_wb}, 32'd0);
                pend_acc = 0; pend_wb = 0;
            end else begin
                exp_v = (sb.size() > 0) && (sb[0].cyc + 1 == cyc);
                check("R1 rsp_valid timing", {31'b0, rsp_valid}, {31'b0, exp_v});
                exp_acc = pend_acc; exp_wb = pend_wb;
                pend_acc = 0; pend_wb = 0;
                if (exp_v) begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag, " addr"}, rsp_addr, e.addr);
                    check({e.tag, " wb_en"}, {31'b0, rsp_wb_en}, {31'b0, e.wb_en});
                    if (e.wb_en) check({e.tag, " wb_data"}, rsp_wb_data, e.wb_data);
                    exp_acc |= e.acc1; exp_wb |= e.wb1;
                    pend_acc = e.acc2; pend_wb = e.wb2;
                end
                check("R8 R9 seq_access", {31'b0, seq_access}, {31'b0, exp_acc});
                check("R8 R9 seq_wb", {31'b0, seq_wb}, {31'b0, exp_wb});
            end
        end
    end

    initial begin : watchdog
        #1000000;
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        idle(3);
        rst_n = 1;
        idle(1);
        // R2 R5: plain add and subtract of immediate, zero-extension
        send(2'd0, 0, 0, 32'h1000, 12'h024, 0, 0, 0, 0, 32'h24, "R2 R5 plain add", 0);
        idle(2);
        send(2'd0, 1, 0, 32'h1000, 12'h010, 0, 0, 0, 0, 32'h10, "R2 plain sub", 0);
        idle(2);
        send(2'd0, 0, 0, 32'h0, 12'hFFF, 0, 0, 0, 0, 32'hFFF, "R2 imm zero-extend", 0);
        idle(2);
        // R3 R6 R8: pre-indexed with left shift
        send(2'd1, 0, 1, 32'h2000, 0, 32'h3, 3'd0, 5'd2, 0, 32'hC, "R3 R6 R8 pre lsl", 0);
        idle(3);
        // R7 R9: post-indexed subtract with logical right shift
        send(2'd2, 1, 1, 32'h3000, 0, 32'h100, 3'd1, 5'd4, 0, 32'h10, "R3 R7 R9 post lsr", 0);
        idle(3);
        // R3 R2: arithmetic right shift and modular wrap
        send(2'd1, 0, 1, 32'h0800_0000, 0, 32'h8000_0000, 3'd2, 5'd4, 0, 32'hF800_0000, "R3 R2 asr wrap", 0);
        idle(3);
        send(2'd0, 0, 1, 32'h0, 0, 32'h0000_00F1, 3'd3, 5'd4, 0, 32'h1000_000F, "R3 ror", 0);
        idle(2);
        send(2'd0, 0, 1, 32'h0, 0, 32'h0000_ABCD, 3'd3, 5'd0, 0, 32'h0000_ABCD, "R3 zero amount", 0);
        idle(2);
        // R4: rotate with carry ignores amount; codes above pass through
        send(2'd0, 0, 1, 32'h0, 0, 32'h3, 3'd4, 5'd7, 1, 32'h8000_0001, "R4 rrx carry1", 0);
        idle(2);
        send(2'd0, 0, 1, 32'h10, 0, 32'h2, 3'd4, 5'd0, 0, 32'h1, "R4 rrx carry0", 0);
        idle(2);
        send(2'd0, 0, 1, 32'h0, 0, 32'h55, 3'd5, 5'd3, 0, 32'h55, "R4 code5 pass", 0);
        idle(2);
        send(2'd0, 0, 1, 32'h0, 0, 32'h77, 3'd7, 5'd9, 0, 32'h77, "R4 code7 pass", 0);
        idle(2);
        // R10: mode 3 as plain
        send(2'd3, 0, 0, 32'h500, 12'h00C, 0, 0, 0, 0, 32'hC, "R10 mode3", 0);
        idle(2);
        // R7 R2: post with subtract wrap
        send(2'd2, 1, 0, 32'h4, 12'h008, 0, 0, 0, 0, 32'h8, "R7 R2 post sub wrap", 0);
        idle(3);
        // R8 R9: back-to-back requests merge strobes
        send(2'd1, 0, 0, 32'h100, 12'h004, 0, 0, 0, 0, 32'h4, "R8 b2b pre", 1);
        send(2'd2, 0, 0, 32'h200, 12'h008, 0, 0, 0, 0, 32'h8, "R9 b2b post", 1);
        send(2'd1, 1, 0, 32'h300, 12'h010, 0, 0, 0, 0, 32'h10, "R8 b2b pre2", 0);
        idle(4);
        // R11: reset mid-stream clears strobes
        send(2'd1, 0, 0, 32'h40, 12'h001, 0, 0, 0, 0, 32'h1, "R11 pre before reset", 0);
        idle(2);
        rst_n = 0;
        sb.delete();
        idle(3);
        rst_n = 1;
        idle(3);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule